// File: doc/BRIEF.md
# Stage-2 Translation Cache with Address-Targeted Invalidation

This block is a small, fully associative translation cache for stage-2-only entries. Each entry maps an intermediate physical page to an output page. The entry also carries a VMID tag, an IPA-space bit, a translation granule, a walk level and a flag that marks it as a leaf of the walk. Fills write entries in rotating order. A combinational lookup returns the translated output page for the current VMID, using the page size that the entry's granule and level define.

The block also accepts a 64-bit invalidate-by-IPA command. A one-cycle request latches the packed operand together with the current VMID, the security state and the 52-bit address mode. The scan controller then visits one entry per cycle. It clears every valid leaf entry of the latched VMID whose IPA space and masked address match the operand. An optional level hint can narrow the match further. A one-cycle done pulse follows the last entry. While the scan runs, lookups are stalled and report a miss.

Top module: `s2tlb_ipa_inv`

## Requirements
- R1: After reset no entry is valid: every lookup misses, and `lk_stall` and `inv_done` are low.
- R2: A fill writes the slot under a rotating pointer that starts at slot 0 and advances by one per fill. With 8 slots, the ninth fill evicts the first entry written and leaves the second in place.
- R3: A lookup hits when a valid entry has a VMID equal to `cur_vmid`, an IPA-space bit equal to `lk_ns`, and an IPA page number equal to `lk_ipn` above the entry's low-bit count. The granule codes are 01 = 4KB, 10 = 16KB and 11 = 64KB, and the level codes are 01, 10 and 11. The low-bit counts for 4KB are 0 at level 3, 9 at level 2 and 18 at level 1. For 16KB they are 2 at level 3 and 13 at level 2. For 64KB they are 4 at level 3, 17 at level 2 and 30 at level 1. `lk_opn` takes the entry's output page above that count and `lk_ipn` below it.
- R4: A request arriving with the scan idle is accepted at that clock edge. `lk_stall` is then high for exactly 8 cycles, during which `lk_hit` is 0. `inv_done` is high for the single cycle that follows. A request that arrives during a scan has no effect.
- R5: An invalidate clears only entries that have the leaf flag set and whose VMID equals the `cur_vmid` sampled when the request was accepted.
- R6: The operand places the IPA-space select at bit 63, the level hint at bits 47:44, IPA[51:48] at bits 39:36 and IPA[47:12] at bits 35:0. Bits 62:48 and 43:40 are ignored. The address is compared above the entry's low-bit count, so any address inside a block entry clears it.
- R7: The operand space bit selects the target space: 1 = non-secure, 0 = secure. The bit is used only when `sec_state` is 1 and `sec_s2_en` is 1. Otherwise only non-secure entries are targeted.
- R8: A hint gives no level information when its bits 3:2 are 00, when its bits 1:0 are 00, or when it equals 1001. In that case entries of every granule and level are candidates.
- R9: Any other hint restricts clearing to entries whose granule equals hint bits 3:2 and whose level equals hint bits 1:0. Other entries stay valid.
- R10: Operand bits 39:36 take part in the compare only when `lpa52_en` is 1 and the entry uses the 64KB granule. In every other case they are compared as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_vmid | input | 16 | Current VMID, used by lookups and sampled at invalidate accept |
| sec_state | input | 1 | 1 when the command runs in secure state |
| sec_s2_en | input | 1 | 1 when secure stage 2 is present and enabled |
| lpa52_en | input | 1 | 52-bit intermediate addressing active |
| fill_en | input | 1 | Write one entry at the rotating pointer |
| fill_vmid | input | 16 | VMID tag of the fill |
| fill_ns | input | 1 | IPA space of the fill (1 = non-secure) |
| fill_gran | input | 2 | Granule code of the fill |
| fill_lvl | input | 2 | Walk level code of the fill |
| fill_last | input | 1 | Fill is a leaf of the walk |
| fill_ipn | input | 40 | IPA page number (IPA[51:12]) of the fill |
| fill_opn | input | 40 | Output page number of the fill |
| lk_ns | input | 1 | IPA space of the lookup |
| lk_ipn | input | 40 | IPA page number to translate |
| lk_hit | output | 1 | Lookup hit (0 while stalled) |
| lk_opn | output | 40 | Translated output page number |
| lk_stall | output | 1 | Invalidate scan in progress |
| inv_req | input | 1 | Invalidate request |
| inv_op | input | 64 | Packed invalidate operand |
| inv_done | output | 1 | One-cycle pulse after the scan ends |

## Verification
Each invalidate pattern runs against a table that holds both entries that should die and near-miss neighbours. Address, VMID, space, leaf-flag and hint filtering are therefore each exposed by the entry that survives. The neighbours differ in one way each: an adjacent page, a foreign VMID, a non-leaf entry, the opposite IPA space, or a different granule or level. Hint values are tried in three classes: absent, reserved and exact. These tell the "any level" path apart from the narrowing path. Block entries, probed with an interior address, tell page-size masking apart from a full-width compare. Upper address bits are tried with 52-bit mode on and off, and against 64KB and 4KB entries.

// File: rtl/s2tlb_pkg.sv
package s2tlb_pkg;
  localparam int VMID_W = 16;
  localparam int IPN_W  = 40;
  localparam int OP_W   = 64;

  localparam logic [1:0] GR_4K  = 2'b01;
  localparam logic [1:0] GR_16K = 2'b10;
  localparam logic [1:0] GR_64K = 2'b11;

  typedef struct packed {
    logic              valid;
    logic [VMID_W-1:0] vmid;
    logic              ns;
    logic [1:0]        gran;
    logic [1:0]        lvl;
    logic              last;
    logic [IPN_W-1:0]  ipn;
  } tag_t;

  typedef struct packed {
    tag_t             tag;
    logic [IPN_W-1:0] opn;
  } ent_t;

  // Number of 4KB page-number bits covered by one entry
  function automatic logic [4:0] low_bits(input logic [1:0] g, input logic [1:0] l);
    case ({g, l})
      4'b0111: low_bits = 5'd0;
      4'b0110: low_bits = 5'd9;
      4'b0101: low_bits = 5'd18;
      4'b1011: low_bits = 5'd2;
      4'b1010: low_bits = 5'd13;
      4'b1111: low_bits = 5'd4;
      4'b1110: low_bits = 5'd17;
      4'b1101: low_bits = 5'd30;
      default: low_bits = 5'd0;
    endcase
  endfunction

  function automatic logic [IPN_W-1:0] pg_mask(input logic [1:0] g, input logic [1:0] l);
    pg_mask = {IPN_W{1'b1}} << low_bits(g, l);
  endfunction

  // Hint carries no usable level information
  function automatic logic hint_void(input logic [3:0] h);
    hint_void = (h[3:2] == 2'b00) || (h[1:0] == 2'b00) ||
                (h[3:2] == GR_16K && h[1:0] == 2'b01);
  endfunction
endpackage

// File: rtl/s2tlb_op_decode.sv
module s2tlb_op_decode
  import s2tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  op,
  input  logic             sec_state,
  input  logic             sec_s2_en,
  output logic             tgt_ns,
  output logic [IPN_W-1:0] tgt_ipn,
  output logic             hint_on,
  output logic [1:0]       hint_gran,
  output logic [1:0]       hint_lvl
);
  logic [3:0]  hint;
  logic [18:0] rsvd_bits;
  logic [45:0] live_bits;

  assign hint      = op[47:44];
  assign rsvd_bits = {op[62:48], op[43:40]};
  assign live_bits = {op[63], op[47:44], op[39:0], sec_state};

  assign tgt_ns    = (sec_state && sec_s2_en) ? op[63] : 1'b1;
  assign tgt_ipn   = op[39:0];
  assign hint_on   = !hint_void(hint);
  assign hint_gran = hint[3:2];
  assign hint_lvl  = hint[1:0];

  // R6: reserved operand bits never change the decoded command
  a_r6_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rsvd_bits) && $stable(live_bits) && $stable(sec_s2_en)) |->
      $stable({tgt_ns, tgt_ipn, hint_on, hint_gran, hint_lvl}));
endmodule

// File: rtl/s2tlb_scan_ctl.sv
module s2tlb_scan_ctl
  import s2tlb_pkg::*;
#(
  parameter int NUM_ENT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inv_req,
  input  logic                     tgt_ns,
  input  logic [IPN_W-1:0]         tgt_ipn,
  input  logic                     hint_on,
  input  logic [1:0]               hint_gran,
  input  logic [1:0]               hint_lvl,
  input  logic [VMID_W-1:0]        cur_vmid,
  input  logic                     lpa52_en,
  input  tag_t [NUM_ENT-1:0]       tags,
  output logic                     busy,
  output logic                     done,
  output logic [NUM_ENT-1:0]       clr_vec
);
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENT - 1);

  logic [IDX_W-1:0]  idx;
  logic              r_ns, r_hon, r_lpa;
  logic [1:0]        r_hg, r_hl;
  logic [IPN_W-1:0]  r_ipn;
  logic [VMID_W-1:0] r_vmid;

  logic              accept, at_last, hit_now, hint_ok, addr_ok;
  tag_t              cur;
  logic [IPN_W-1:0]  eff_ipn;

  assign accept  = inv_req && !busy;
  assign at_last = (idx == LAST_IDX);
  assign cur     = tags[idx];

  always_comb begin
    eff_ipn = (r_lpa && cur.gran == GR_64K) ? r_ipn : {4'b0000, r_ipn[IPN_W-5:0]};
    addr_ok = (((cur.ipn ^ eff_ipn) & pg_mask(cur.gran, cur.lvl)) == '0);
    hint_ok = !r_hon || (cur.gran == r_hg && cur.lvl == r_hl);
    hit_now = cur.valid && cur.last && (cur.vmid == r_vmid) &&
              (cur.ns == r_ns) && hint_ok && addr_ok;
    clr_vec = '0;
    if (busy && hit_now) clr_vec[idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      idx    <= '0;
      r_ns   <= 1'b1;
      r_ipn  <= '0;
      r_hon  <= 1'b0;
      r_hg   <= '0;
      r_hl   <= '0;
      r_vmid <= '0;
      r_lpa  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        idx    <= '0;
        r_ns   <= tgt_ns;
        r_ipn  <= tgt_ipn;
        r_hon  <= hint_on;
        r_hg   <= hint_gran;
        r_hl   <= hint_lvl;
        r_vmid <= cur_vmid;
        r_lpa  <= lpa52_en;
      end else if (busy) begin
        if (at_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R4: done is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4: done only directly after a scan cycle, with the scan finished
  a_r4_done_after_scan: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  // R4: a request during the scan does not restart the walk
  a_r4_scan_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !at_last) |=> (busy && idx == $past(idx) + 1'b1));
endmodule

// File: rtl/s2tlb_entry_store.sv
module s2tlb_entry_store
  import s2tlb_pkg::*;
#(
  parameter int NUM_ENT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en,
  input  ent_t               fill_ent,
  input  logic [NUM_ENT-1:0] clr_vec,
  output ent_t [NUM_ENT-1:0] ents
);
  localparam int PTR_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(NUM_ENT - 1);

  logic [PTR_W-1:0]   rr_ptr;
  logic [NUM_ENT-1:0] wr_vec;

  always_comb begin
    wr_vec = '0;
    if (fill_en) wr_vec[rr_ptr] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rr_ptr <= '0;
    else if (fill_en) rr_ptr <= (rr_ptr == PTR_MAX) ? '0 : rr_ptr + 1'b1;
  end

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ents[i] <= '0;
      end else if (wr_vec[i]) begin
        ents[i]           <= fill_ent;
        ents[i].tag.valid <= 1'b1;
      end else if (clr_vec[i]) begin
        ents[i].tag.valid <= 1'b0;
      end
    end

    // R5: the scan only ever kills leaf entries
    a_r5_kill_leaf: assert property (@(posedge clk) disable iff (!rst_n)
      clr_vec[i] |-> (ents[i].tag.last && ents[i].tag.valid));
  end

  // R2: a fill writes exactly one slot
  a_r2_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec) && (fill_en == (wr_vec != '0)));
  // R4: the scan clears at most one slot per cycle
  a_r4_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));
endmodule

// File: rtl/s2tlb_ipa_inv.sv
module s2tlb_ipa_inv
  import s2tlb_pkg::*;
#(
  parameter int NUM_ENT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cur_vmid,
  input  logic              sec_state,
  input  logic              sec_s2_en,
  input  logic              lpa52_en,
  input  logic              fill_en,
  input  logic [15:0]       fill_vmid,
  input  logic              fill_ns,
  input  logic [1:0]        fill_gran,
  input  logic [1:0]        fill_lvl,
  input  logic              fill_last,
  input  logic [39:0]       fill_ipn,
  input  logic [39:0]       fill_opn,
  input  logic              lk_ns,
  input  logic [39:0]       lk_ipn,
  output logic              lk_hit,
  output logic [39:0]       lk_opn,
  output logic              lk_stall,
  input  logic              inv_req,
  input  logic [63:0]       inv_op,
  output logic              inv_done
);
  ent_t               fill_ent;
  ent_t [NUM_ENT-1:0] ents;
  tag_t [NUM_ENT-1:0] tags;
  logic [NUM_ENT-1:0] clr_vec;
  logic [NUM_ENT-1:0] hit_v;
  logic               tgt_ns, hint_on, scan_busy, scan_done, any_hit;
  logic [IPN_W-1:0]   tgt_ipn, sel_mask;
  logic [1:0]         hint_gran, hint_lvl;
  ent_t               sel;

  assign fill_ent = '{tag: '{valid: 1'b1, vmid: fill_vmid, ns: fill_ns,
                             gran: fill_gran, lvl: fill_lvl, last: fill_last,
                             ipn: fill_ipn},
                      opn: fill_opn};

  s2tlb_op_decode u_dec (
    .clk(clk), .rst_n(rst_n), .op(inv_op), .sec_state(sec_state),
    .sec_s2_en(sec_s2_en), .tgt_ns(tgt_ns), .tgt_ipn(tgt_ipn),
    .hint_on(hint_on), .hint_gran(hint_gran), .hint_lvl(hint_lvl)
  );

  s2tlb_scan_ctl #(.NUM_ENT(NUM_ENT)) u_scan (
    .clk(clk), .rst_n(rst_n), .inv_req(inv_req), .tgt_ns(tgt_ns),
    .tgt_ipn(tgt_ipn), .hint_on(hint_on), .hint_gran(hint_gran),
    .hint_lvl(hint_lvl), .cur_vmid(cur_vmid), .lpa52_en(lpa52_en),
    .tags(tags), .busy(scan_busy), .done(scan_done), .clr_vec(clr_vec)
  );

  s2tlb_entry_store #(.NUM_ENT(NUM_ENT)) u_store (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_ent(fill_ent),
    .clr_vec(clr_vec), .ents(ents)
  );

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_lookup
    assign tags[i]  = ents[i].tag;
    assign hit_v[i] = ents[i].tag.valid && (ents[i].tag.vmid == cur_vmid) &&
                      (ents[i].tag.ns == lk_ns) &&
                      (((ents[i].tag.ipn ^ lk_ipn) &
                        pg_mask(ents[i].tag.gran, ents[i].tag.lvl)) == '0);
  end

  // Lowest matching slot wins
  always_comb begin
    any_hit = 1'b0;
    sel     = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        any_hit = 1'b1;
        sel     = ents[i];
      end
    end
    sel_mask = pg_mask(sel.tag.gran, sel.tag.lvl);
  end

  assign lk_hit   = any_hit && !scan_busy;
  assign lk_opn   = any_hit ? ((sel.opn & sel_mask) | (lk_ipn & ~sel_mask)) : '0;
  assign lk_stall = scan_busy;
  assign inv_done = scan_done;

  // R4: the stall has dropped by the time done is signalled
  a_r4_done_unstalled: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done |-> !lk_stall);
endmodule

// File: tb/sim_s2tlb_ipa_inv.sv
module sim_s2tlb_ipa_inv;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cur_vmid;
  logic        sec_state, sec_s2_en, lpa52_en;
  logic        fill_en, fill_ns, fill_last;
  logic [15:0] fill_vmid;
  logic [1:0]  fill_gran, fill_lvl;
  logic [39:0] fill_ipn, fill_opn, lk_ipn, lk_opn;
  logic        lk_ns, lk_hit, lk_stall, inv_req, inv_done;
  logic [63:0] inv_op;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  s2tlb_ipa_inv #(.NUM_ENT(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cur_vmid(cur_vmid), .sec_state(sec_state),
    .sec_s2_en(sec_s2_en), .lpa52_en(lpa52_en), .fill_en(fill_en),
    .fill_vmid(fill_vmid), .fill_ns(fill_ns), .fill_gran(fill_gran),
    .fill_lvl(fill_lvl), .fill_last(fill_last), .fill_ipn(fill_ipn),
    .fill_opn(fill_opn), .lk_ns(lk_ns), .lk_ipn(lk_ipn), .lk_hit(lk_hit),
    .lk_opn(lk_opn), .lk_stall(lk_stall), .inv_req(inv_req),
    .inv_op(inv_op), .inv_done(inv_done)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_op(input logic ns, input logic [3:0] hint,
                                        input logic [39:0] ipn);
    return {ns, 15'h0, hint, 4'h0, ipn};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cur_vmid = 16'd5; sec_state = 1'b0; sec_s2_en = 1'b0;
    lpa52_en = 1'b0; fill_en = 1'b0; fill_vmid = '0; fill_ns = 1'b1;
    fill_gran = 2'b01; fill_lvl = 2'b11; fill_last = 1'b1; fill_ipn = '0;
    fill_opn = '0; lk_ns = 1'b1; lk_ipn = '0; inv_req = 1'b0; inv_op = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic fill(input logic [15:0] v, input logic ns, input logic [1:0] g,
                      input logic [1:0] l, input logic last,
                      input logic [39:0] ipn, input logic [39:0] opn);
    fill_en = 1'b1; fill_vmid = v; fill_ns = ns; fill_gran = g; fill_lvl = l;
    fill_last = last; fill_ipn = ipn; fill_opn = opn;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic look(input string tag, input logic ns, input logic [39:0] ipn,
                      input logic exp_hit, input logic [39:0] exp_opn);
    lk_ns = ns; lk_ipn = ipn;
    #1;
    chk({tag, " hit"}, {63'h0, lk_hit}, {63'h0, exp_hit});
    if (exp_hit) chk({tag, " opn"}, {24'h0, lk_opn}, {24'h0, exp_opn});
  endtask

  task automatic inv(input logic [63:0] op);
    int k;
    inv_op = op; inv_req = 1'b1;
    @(negedge clk);
    inv_req = 1'b0;
    k = 1;
    while (!inv_done && k < 40) begin
      @(negedge clk);
      k++;
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 stall", {63'h0, lk_stall}, 64'h0);
    chk("R1 done", {63'h0, inv_done}, 64'h0);
    look("R1 lookup", 1'b1, 40'h0, 1'b0, 40'h0);
    look("R1 lookup2", 1'b0, 40'h12345, 1'b0, 40'h0);
  endtask

  task automatic t_lookup();
    do_reset();
    fill(16'd5, 1'b1, 2'b01, 2'b11, 1'b1, 40'h12345, 40'hAAAAA);
    fill(16'd5, 1'b1, 2'b01, 2'b10, 1'b1, 40'h200, 40'h55400);
    fill(16'd5, 1'b1, 2'b11, 2'b10, 1'b1, 40'h60000, 40'hA00000);
    look("R3 4K L3", 1'b1, 40'h12345, 1'b1, 40'hAAAAA);
    look("R3 4K L3 neighbour", 1'b1, 40'h12344, 1'b0, 40'h0);
    look("R3 4K L2 block", 1'b1, 40'h233, 1'b1, 40'h55433);
    look("R3 64K L2 block", 1'b1, 40'h7FFFF, 1'b1, 40'hA1FFFF);
    look("R3 space mismatch", 1'b0, 40'h12345, 1'b0, 40'h0);
    cur_vmid = 16'd6;
    look("R3 vmid mismatch", 1'b1, 40'h12345, 1'b0, 40'h0);
  endtask

  task automatic t_round_robin();
    do_reset();
    for (int i = 0; i < N + 1; i++)
      fill(16'd5, 1'b1, 2'b01, 2'b11, 1'b1, 40'h1000 + 40'(i), 40'h9000 + 40'(i));
    look("R2 first evicted", 1'b1, 40'h1000, 1'b0, 40'h0);
    look("R2 second kept", 1'b1, 40'h1001, 1'b1, 40'h9001);
    look("R2 ninth present", 1'b1, 40'h1000 + 40'(N), 1'b1, 40'h9000 + 40'(N));
  endtask

  task automatic t_timing();
    do_reset();
    fill(16'd5, 1'b1, 2'b01, 2'b11, 1'b1, 40'h12345, 40'hAAAAA);
    inv_op = mk_op(1'b1, 4'h0, 40'h777); inv_req = 1'b1;
    @(negedge clk);
    inv_req = 1'b0;
    for (int k = 1; k <= N; k++) begin
      if (k == 3) begin
        inv_op = mk_op(1'b1, 4'h0, 40'h12345); inv_req = 1'b1;
      end
      if (k == 4) inv_req = 1'b0;
      if (k == 1 || k == N) begin
        chk("R4 stall during scan", {63'h0, lk_stall}, 64'h1);
        chk("R4 done low during scan", {63'h0, inv_done}, 64'h0);
      end
      if (k == 2) look("R4 lookup stalled", 1'b1, 40'h12345, 1'b0, 40'h0);
      @(negedge clk);
    end
    chk("R4 done pulse", {63'h0, inv_done}, 64'h1);
    chk("R4 stall released", {63'h0, lk_stall}, 64'h0);
    @(negedge clk);
    chk("R4 done single", {63'h0, inv_done}, 64'h0);
    look("R4 request in scan ignored", 1'b1, 40'h12345, 1'b1, 40'hAAAAA);
  endtask

  task automatic t_vmid_leaf();
    do_reset();
    fill(16'd5, 1'b1, 2'b01, 2'b11, 1'b1, 40'h12345, 40'hAAAAA);
    fill(16'd6, 1'b1, 2'b01, 2'b11, 1'b1, 40'h12345, 40'hBBBBB);
    fill(16'd5, 1'b1, 2'b01, 2'b11, 1'b0, 40'h4444, 40'hCCCCC);
    fill(16'd5, 1'b1, 2'b01, 2'b11, 1'b1, 40'h12346, 40'hDDDDD);
    inv(mk_op(1'b1, 4'h0, 40'h12345));
    look("R5 own vmid cleared", 1'b1, 40'h12345, 1'b0, 40'h0);
    look("R6 adjacent page kept", 1'b1, 40'h12346, 1'b1, 40'hDDDDD);
    inv(mk_op(1'b1, 4'h0, 40'h4444));
    look("R5 non-leaf kept", 1'b1, 40'h4444, 1'b1, 40'hCCCCC);
    cur_vmid = 16'd6;
    look("R5 other vmid kept", 1'b1, 40'h12345, 1'b1, 40'hBBBBB);
  endtask

  task automatic t_operand();
    do_reset();
    fill(16'd5, 1'b1, 2'b01, 2'b11, 1'b1, 40'h12345, 40'hAAAAA);
    fill(16'd5, 1'b1, 2'b01, 2'b10, 1'b1, 40'h200, 40'h55400);
    inv(mk_op(1'b1, 4'h0, 40'h12345) | 64'h7FFF_0F00_0000_0000);
    look("R6 reserved bits ignored", 1'b1, 40'h12345, 1'b0, 40'h0);
    inv(mk_op(1'b1, 4'h0, 40'h233));
    look("R6 block cleared by interior address", 1'b1, 40'h200, 1'b0, 40'h0);
  endtask

  task automatic t_space();
    do_reset();
    fill(16'd5, 1'b0, 2'b01, 2'b11, 1'b1, 40'h12345, 40'h11111);
    fill(16'd5, 1'b1, 2'b01, 2'b11, 1'b1, 40'h12345, 40'h22222);
    sec_state = 1'b1; sec_s2_en = 1'b1;
    inv(mk_op(1'b0, 4'h0, 40'h12345));
    look("R7 secure target cleared", 1'b0, 40'h12345, 1'b0, 40'h0);
    look("R7 non-secure kept", 1'b1, 40'h12345, 1'b1, 40'h22222);
    do_reset();
    fill(16'd5, 1'b0, 2'b01, 2'b11, 1'b1, 40'h12345, 40'h11111);
    fill(16'd5, 1'b1, 2'b01, 2'b11, 1'b1, 40'h12345, 40'h22222);
    inv(mk_op(1'b0, 4'h0, 40'h12345));
    look("R7 ns state forces ns", 1'b1, 40'h12345, 1'b0, 40'h0);
    look("R7 ns state secure kept", 1'b0, 40'h12345, 1'b1, 40'h11111);
    do_reset();
    fill(16'd5, 1'b1, 2'b01, 2'b11, 1'b1, 40'h12345, 40'h22222);
    sec_state = 1'b1; sec_s2_en = 1'b0;
    inv(mk_op(1'b0, 4'h0, 40'h12345));
    look("R7 secure s2 off forces ns", 1'b1, 40'h12345, 1'b0, 40'h0);
  endtask

  task automatic t_hint_any();
    logic [3:0] hv [4] = '{4'h0, 4'h9, 4'h4, 4'h3};
    for (int i = 0; i < 4; i++) begin
      do_reset();
      fill(16'd5, 1'b1, 2'b01, 2'b11, 1'b1, 40'h12345, 40'hAAAAA);
      inv(mk_op(1'b1, hv[i], 40'h12345));
      look($sformatf("R8 void hint %h clears", hv[i]), 1'b1, 40'h12345, 1'b0, 40'h0);
    end
  endtask

  task automatic t_hint_exact();
    do_reset();
    fill(16'd5, 1'b1, 2'b01, 2'b11, 1'b1, 40'h12345, 40'hAAAAA);
    inv(mk_op(1'b1, 4'h6, 40'h12345));
    look("R9 level mismatch kept", 1'b1, 40'h12345, 1'b1, 40'hAAAAA);
    inv(mk_op(1'b1, 4'hF, 40'h12345));
    look("R9 granule mismatch kept", 1'b1, 40'h12345, 1'b1, 40'hAAAAA);
    inv(mk_op(1'b1, 4'h7, 40'h12345));
    look("R9 exact hint clears", 1'b1, 40'h12345, 1'b0, 40'h0);
  endtask

  task automatic t_upper();
    do_reset();
    fill(16'd5, 1'b1, 2'b11, 2'b11, 1'b1, 40'h30_0000_0010, 40'h00_0ABC_0000);
    fill(16'd5, 1'b1, 2'b01, 2'b11, 1'b1, 40'h777, 40'h888);
    look("R10 64K entry present", 1'b1, 40'h30_0000_0013, 1'b1, 40'h00_0ABC_0003);
    inv(mk_op(1'b1, 4'h0, 40'h30_0000_0010));
    look("R10 upper bits zeroed without 52-bit", 1'b1, 40'h30_0000_0010, 1'b1, 40'h00_0ABC_0000);
    lpa52_en = 1'b1;
    inv(mk_op(1'b1, 4'h0, 40'h50_0000_0777));
    look("R10 4K entry ignores upper bits", 1'b1, 40'h777, 1'b0, 40'h0);
    inv(mk_op(1'b1, 4'h0, 40'h30_0000_0010));
    look("R10 52-bit 64K compare clears", 1'b1, 40'h30_0000_0010, 1'b0, 40'h0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_lookup();
    t_round_robin();
    t_timing();
    t_vmid_leaf();
    t_operand();
    t_space();
    t_hint_any();
    t_hint_exact();
    t_upper();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule